// File: doc/BRIEF.md
# Serial Boot Mode Loader

This block runs once per power-up. It reads a serial configuration stream from an external mode source into a wide mode register before the rest of the core is released from reset. A rising edge on the power-good input starts the read. The loader then drives a slow mode clock, derived by dividing the system clock, and captures one serial data bit on each rising edge of that clock. It shifts the bits in least significant bit first.

When the last bit is in, the loader raises a done flag, drops its reset hold on the core and freezes the mode register. Three fields are then decoded:

- Endianness: taken from the stream or from an external pin.
- Output-drive timing code.
- Mandatory bits: three bits that must read as one. An error flag is raised if any of them is zero.

A drive timing code with both bits equal is also flagged. Dropping power-good in the middle of a read aborts it. The next rising edge of power-good starts over from bit 0.

Top module: `boot_mode_loader`

## Requirements
- R1: After reset, modeClk is 0, modeDone is 0, coreHold is 1, modeWord is all zeros, and driveTiming, driveBad and mandatoryErr are all 0.
- R2: A rising edge of powerGood (sampled 1 at a clock edge after being sampled 0 at the previous edge) starts a load at that edge. After that edge, modeDone is 0, coreHold is 1 and modeWord is all zeros.
- R3: During a load, modeClk is periodic with a period of DIV system clocks. It is low for the first DIV/2 cycles after the start edge and high for the next DIV/2 cycles. Counting the start edge as edge k, modeClk is high after edge k+j exactly when (j mod DIV) >= DIV/2. Outside a load it stays low.
- R4: modeIn is sampled at each edge where modeClk rises. After NBITS samples, modeWord[i] holds the i-th sampled bit, with the first bit landing in bit 0.
- R5: modeDone rises, and coreHold falls, at the same edge that captures the last bit, edge k+DIV/2+(NBITS-1)*DIV. Before that edge, modeDone stays 0 and coreHold stays 1.
- R6: Once modeDone is 1, modeWord, modeDone and coreHold are unaffected by modeIn and by powerGood going low. modeClk stays low. Only a new rising edge of powerGood restarts the load.
- R7: If powerGood is sampled low during a load, the load is aborted at that edge. After that edge, modeClk is 0, modeDone is 0 and coreHold is 1. The next rising edge of powerGood reloads from bit 0.
- R8: bigEndian is 1 when modeDone is 1 and modeWord[8] is 1. Otherwise it equals endianPin.
- R9: When modeDone is 1, driveTiming equals modeWord[14:13] (2'b10 is fastest, 2'b01 is slowest) and driveBad is 1 if that code is 2'b00 or 2'b11. When modeDone is 0, both are 0.
- R10: mandatoryErr is 1 exactly when modeDone is 1 and any of modeWord[20], modeWord[33] or modeWord[37] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerGood | input | 1 | Supply good; a rising edge starts a load, synchronous to sysClk |
| modeIn | input | 1 | Serial mode data |
| endianPin | input | 1 | External endianness select |
| modeClk | output | 1 | Mode clock, sysClk divided by DIV during a load |
| modeDone | output | 1 | Mode register loaded and frozen |
| coreHold | output | 1 | Holds the rest of the core in reset until done |
| modeWord | output | NBITS | Loaded mode register |
| bigEndian | output | 1 | Effective endianness, 1 = big |
| driveTiming | output | 2 | Output-drive timing code |
| driveBad | output | 1 | Drive timing code is 00 or 11 |
| mandatoryErr | output | 1 | A mandatory-one bit read as 0 |

## Verification
Every result is timed from the edge k that samples the powerGood rise:

- The clear of modeWord and the done/hold state are due right after edge k.
- The modeClk level after edge k+j follows j mod DIV.
- Bit m is captured at edge k+DIV/2+m*DIV.
- modeDone and the decoded fields are due after edge k+DIV/2+(NBITS-1)*DIV. An abort shows after the single edge that samples powerGood low.

The bench counts these edges itself. It samples on the falling clock edge, so each check reads the value left by exactly the edge it is counting. It updates modeIn just after each capture, which keeps the next bit stable for a full mode clock period.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

  // Field positions decoded after a load; neighbours rely on them.
  localparam int ENDIAN_SEL_BIT = 8;
  localparam int DRIVE_LSB      = 13;
  localparam int NUM_FIXED      = 3;
  localparam int FIXED_ONE_BITS [NUM_FIXED] = '{20, 33, 37};
  localparam int MIN_BITS       = 38;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_DONE = 2'd2
  } seqState_t;

  // Strobes from the sequencer to the shift register.
  typedef struct packed {
    logic clearWord;
    logic shiftBit;
  } seqStrobe_t;

endpackage

// File: rtl/bml_sequencer.sv
module bml_sequencer
  import boot_mode_pkg::*;
#(
  parameter int NBITS = 256,
  parameter int DIV   = 256
) (
  input  logic       sysClk,
  input  logic       rstN,
  input  logic       powerGood,
  output seqStrobe_t strobe,
  output logic       modeClk,
  output logic       modeDone,
  output logic       coreHold
);

  localparam int HALF  = DIV / 2;
  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int CNT_W = $clog2(NBITS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(DIV - 1);
  localparam logic [DIV_W-1:0] HALF_LAST = DIV_W'(HALF - 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(NBITS - 1);

  seqState_t        state;
  logic             pgQ;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             startLoad;
  logic             captureNow;
  logic             lastBit;

  // A load starts on a sampled rise of power-good.
  assign startLoad  = powerGood && !pgQ && (state != SEQ_LOAD);
  assign captureNow = (state == SEQ_LOAD) && powerGood && (divCnt == HALF_LAST);
  assign lastBit    = captureNow && (bitCnt == BIT_LAST);

  always_comb begin
    strobe.clearWord = startLoad;
    strobe.shiftBit  = captureNow;
  end

  always_ff @(posedge sysClk) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      pgQ      <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      modeClk  <= 1'b0;
      modeDone <= 1'b0;
      coreHold <= 1'b1;
    end else begin
      pgQ <= powerGood;
      case (state)
        SEQ_LOAD: begin
          if (!powerGood) begin
            // Abort: drop the clock, forget progress, keep the core held.
            state   <= SEQ_IDLE;
            divCnt  <= '0;
            bitCnt  <= '0;
            modeClk <= 1'b0;
          end else begin
            divCnt <= (divCnt == DIV_LAST) ? '0 : divCnt + 1'b1;
            if (captureNow) begin
              modeClk <= 1'b1;
              bitCnt  <= bitCnt + 1'b1;
              if (lastBit) begin
                state    <= SEQ_DONE;
                modeDone <= 1'b1;
                coreHold <= 1'b0;
              end
            end else if (divCnt == DIV_LAST) begin
              modeClk <= 1'b0;
            end
          end
        end
        default: begin
          modeClk <= 1'b0;
          if (startLoad) begin
            state    <= SEQ_LOAD;
            divCnt   <= '0;
            bitCnt   <= '0;
            modeDone <= 1'b0;
            coreHold <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/bml_shifter.sv
module bml_shifter
  import boot_mode_pkg::*;
#(
  parameter int NBITS = 256
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             modeIn,
  output logic [NBITS-1:0] word
);

  // First bit in ends up at bit 0 after NBITS shifts.
  always_ff @(posedge sysClk) begin
    if (!rstN) begin
      word <= '0;
    end else if (strobe.clearWord) begin
      word <= '0;
    end else if (strobe.shiftBit) begin
      word <= {modeIn, word[NBITS-1:1]};
    end
  end

endmodule

// File: rtl/bml_decode.sv
module bml_decode
  import boot_mode_pkg::*;
(
  input  logic                 loaded,
  input  logic                 endianPin,
  input  logic                 endianSel,
  input  logic [1:0]           driveCode,
  input  logic [NUM_FIXED-1:0] fixedBits,
  output logic                 bigEndian,
  output logic [1:0]           driveTiming,
  output logic                 driveBad,
  output logic                 mandatoryErr
);

  always_comb begin
    // Stream bit set means big-endian from the stream; clear defers to the pin.
    bigEndian    = endianPin | (loaded & endianSel);
    driveTiming  = loaded ? driveCode : 2'b00;
    driveBad     = loaded & (driveCode[1] == driveCode[0]);
    mandatoryErr = loaded & ~(&fixedBits);
  end

endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader
  import boot_mode_pkg::*;
#(
  parameter int NBITS = 256,
  parameter int DIV   = 256
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             powerGood,
  input  logic             modeIn,
  input  logic             endianPin,
  output logic             modeClk,
  output logic             modeDone,
  output logic             coreHold,
  output logic [NBITS-1:0] modeWord,
  output logic             bigEndian,
  output logic [1:0]       driveTiming,
  output logic             driveBad,
  output logic             mandatoryErr
);

  initial begin
    if (NBITS < MIN_BITS) $error("NBITS too small for decoded fields");
    if (DIV < 4 || (DIV % 2) != 0) $error("DIV must be even and at least 4");
  end

  seqStrobe_t           strobe;
  logic [NUM_FIXED-1:0] fixedBits;

  bml_sequencer #(.NBITS(NBITS), .DIV(DIV)) u_seq (
    .sysClk   (sysClk),
    .rstN     (rstN),
    .powerGood(powerGood),
    .strobe   (strobe),
    .modeClk  (modeClk),
    .modeDone (modeDone),
    .coreHold (coreHold)
  );

  bml_shifter #(.NBITS(NBITS)) u_shift (
    .sysClk(sysClk),
    .rstN  (rstN),
    .strobe(strobe),
    .modeIn(modeIn),
    .word  (modeWord)
  );

  for (genvar g = 0; g < NUM_FIXED; g++) begin : g_fixed
    assign fixedBits[g] = modeWord[FIXED_ONE_BITS[g]];
  end

  bml_decode u_dec (
    .loaded      (modeDone),
    .endianPin   (endianPin),
    .endianSel   (modeWord[ENDIAN_SEL_BIT]),
    .driveCode   (modeWord[DRIVE_LSB+1:DRIVE_LSB]),
    .fixedBits   (fixedBits),
    .bigEndian   (bigEndian),
    .driveTiming (driveTiming),
    .driveBad    (driveBad),
    .mandatoryErr(mandatoryErr)
  );

endmodule

// File: rtl/boot_mode_loader_chk.sv
module boot_mode_loader_chk #(
  parameter int NBITS = 256
) (
  input logic             sysClk,
  input logic             rstN,
  input logic             powerGood,
  input logic             modeClk,
  input logic             modeDone,
  input logic             coreHold,
  input logic [NBITS-1:0] modeWord,
  input logic             driveBad,
  input logic             mandatoryErr
);

  // R2
  start_clears_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(powerGood) |=> (coreHold && !modeDone));

  // R3
  clk_high_holds_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(modeClk) |=> (modeClk || modeDone || !$past(powerGood)));

  // R5
  done_on_last_rise_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(modeDone) |-> $rose(modeClk));

  // R5
  hold_release_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !coreHold |-> modeDone);

  // R6
  word_frozen_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (modeDone && $past(modeDone)) |-> $stable(modeWord));

  // R7
  abort_clk_low_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !powerGood |=> !modeClk);

  // R9
  drive_flag_loaded_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    driveBad |-> modeDone);

  // R10
  mandatory_flag_loaded_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    mandatoryErr |-> modeDone);

endmodule

bind boot_mode_loader boot_mode_loader_chk #(.NBITS(NBITS)) u_chk (
  .sysClk      (sysClk),
  .rstN        (rstN),
  .powerGood   (powerGood),
  .modeClk     (modeClk),
  .modeDone    (modeDone),
  .coreHold    (coreHold),
  .modeWord    (modeWord),
  .driveBad    (driveBad),
  .mandatoryErr(mandatoryErr)
);

// File: tb/test_boot_mode_loader.sv
module test_boot_mode_loader;

  localparam int TB_BITS = 48;
  localparam int TB_DIV  = 8;
  localparam int HALF    = TB_DIV / 2;
  localparam int JEND    = HALF + (TB_BITS - 1) * TB_DIV;

  logic               sysClk = 1'b0;
  logic               rstN = 1'b0;
  logic               powerGood = 1'b0;
  logic               modeIn = 1'b0;
  logic               endianPin = 1'b0;
  logic               modeClk;
  logic               modeDone;
  logic               coreHold;
  logic [TB_BITS-1:0] modeWord;
  logic               bigEndian;
  logic [1:0]         driveTiming;
  logic               driveBad;
  logic               mandatoryErr;

  int errors = 0;
  int checks = 0;

  always #5 sysClk = ~sysClk;

  boot_mode_loader #(.NBITS(TB_BITS), .DIV(TB_DIV)) i_boot_mode_loader (
    .sysClk      (sysClk),
    .rstN        (rstN),
    .powerGood   (powerGood),
    .modeIn      (modeIn),
    .endianPin   (endianPin),
    .modeClk     (modeClk),
    .modeDone    (modeDone),
    .coreHold    (coreHold),
    .modeWord    (modeWord),
    .bigEndian   (bigEndian),
    .driveTiming (driveTiming),
    .driveBad    (driveBad),
    .mandatoryErr(mandatoryErr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic expBig(input logic [TB_BITS-1:0] w, input logic pin);
    return pin | w[8];
  endfunction

  function automatic logic expDriveBad(input logic [TB_BITS-1:0] w);
    return w[14] == w[13];
  endfunction

  function automatic logic expMandErr(input logic [TB_BITS-1:0] w);
    return !(w[20] && w[33] && w[37]);
  endfunction

  // Runs one load; abortAt > 0 drops power-good at that negedge index.
  task automatic runLoad(input logic [TB_BITS-1:0] bits, input int abortAt);
    int clkMiss;
    int m;
    clkMiss = 0;
    @(negedge sysClk);
    powerGood = 1'b0;
    @(negedge sysClk);
    modeIn = bits[0];
    powerGood = 1'b1;
    @(negedge sysClk);  // after start edge k, j = 0
    chk("R2 done cleared", 64'(modeDone), 64'd0);
    chk("R2 hold asserted", 64'(coreHold), 64'd1);
    chk("R2 word cleared", 64'(modeWord), 64'd0);
    for (int j = 0; j < JEND; j++) begin
      if (abortAt > 0 && j == abortAt) begin
        powerGood = 1'b0;
        @(negedge sysClk);
        chk("R7 abort clock low", 64'(modeClk), 64'd0);
        chk("R7 abort done low", 64'(modeDone), 64'd0);
        chk("R7 abort hold kept", 64'(coreHold), 64'd1);
        return;
      end
      if (modeClk !== ((j % TB_DIV) >= HALF)) clkMiss++;
      if (j == JEND - 1) begin
        chk("R5 done not early", 64'(modeDone), 64'd0);
        chk("R5 hold not early", 64'(coreHold), 64'd1);
      end
      m = (j < HALF) ? 0 : (j - HALF) / TB_DIV + 1;
      modeIn = (m < TB_BITS) ? bits[m] : 1'($urandom);
      @(negedge sysClk);
    end
    if (modeClk !== 1'b1) clkMiss++;
    chk("R3 mode clock shape", 64'(clkMiss), 64'd0);
    chk("R5 done at last capture", 64'(modeDone), 64'd1);
    chk("R5 hold released", 64'(coreHold), 64'd0);
    chk("R4 word lsb first", 64'(modeWord), 64'(bits));
  endtask

  task automatic checkDecode(input logic [TB_BITS-1:0] bits);
    chk("R8 endianness", 64'(bigEndian), 64'(expBig(bits, endianPin)));
    chk("R9 drive code", 64'(driveTiming), 64'(bits[14:13]));
    chk("R9 drive bad", 64'(driveBad), 64'(expDriveBad(bits)));
    chk("R10 mandatory error", 64'(mandatoryErr), 64'(expMandErr(bits)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge sysClk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    logic [TB_BITS-1:0] w;
    logic [TB_BITS-1:0] held;
    int clkMiss;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge sysClk);
    // R1 reset state
    chk("R1 modeClk", 64'(modeClk), 64'd0);
    chk("R1 done", 64'(modeDone), 64'd0);
    chk("R1 hold", 64'(coreHold), 64'd1);
    chk("R1 word", 64'(modeWord), 64'd0);
    chk("R1 flags", 64'({driveTiming, driveBad, mandatoryErr}), 64'd0);
    rstN = 1'b1;
    @(negedge sysClk);

    // Directed: legal word, stream selects pin endianness, fastest drive.
    w = '0;
    w[20] = 1'b1; w[33] = 1'b1; w[37] = 1'b1;
    w[14] = 1'b1; w[13] = 1'b0; w[8] = 1'b0;
    w[0] = 1'b1; w[TB_BITS-1] = 1'b1;
    endianPin = 1'b0;
    runLoad(w, 0);
    checkDecode(w);
    endianPin = 1'b1;
    @(negedge sysClk);
    chk("R8 pin selects big", 64'(bigEndian), 64'd1);
    endianPin = 1'b0;

    // R6: frozen after done.
    held = modeWord;
    clkMiss = 0;
    for (int i = 0; i < 20; i++) begin
      modeIn = ~modeIn;
      if (i == 8) powerGood = 1'b0;
      @(negedge sysClk);
      if (modeClk !== 1'b0) clkMiss++;
    end
    chk("R6 word frozen", 64'(modeWord), 64'(held));
    chk("R6 done kept", 64'(modeDone), 64'd1);
    chk("R6 hold released", 64'(coreHold), 64'd0);
    chk("R6 clock idle", 64'(clkMiss), 64'd0);

    // R7: abort while the mode clock is high, then reload from bit 0.
    runLoad({TB_BITS{1'b1}}, 3 * TB_DIV + HALF + 1);
    repeat (5) @(negedge sysClk);
    chk("R7 no clock after abort", 64'(modeClk), 64'd0);
    w = {$urandom, $urandom};
    w[20] = 1'b1; w[33] = 1'b1; w[37] = 1'b1;
    runLoad(w, 0);
    chk("R7 reload word", 64'(modeWord), 64'(w));
    checkDecode(w);

    // Directed: big-endian from stream, slowest drive, one mandatory bit clear.
    w = {$urandom, $urandom};
    w[8] = 1'b1; w[14:13] = 2'b01; w[33] = 1'b0; w[20] = 1'b1; w[37] = 1'b1;
    runLoad(w, 0);
    checkDecode(w);

    // Random loads.
    for (int n = 0; n < 6; n++) begin
      w = {$urandom, $urandom};
      if (n % 2 == 0) begin
        w[20] = 1'b1; w[33] = 1'b1; w[37] = 1'b1;
      end
      endianPin = 1'($urandom);
      runLoad(w, 0);
      checkDecode(w);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule